// File: doc/BRIEF.md
# DSI command packet writer

This block turns one command request into the pushes that a DSI host link expects on its two transmit queues: a 32-bit payload FIFO and a 24-bit packet header FIFO. A request carries a 6-bit data type, a 16-bit byte count and two parameter bytes. The payload bytes of a long write arrive separately on a byte stream that has a valid/ready handshake and a last marker.

The block selects its action from the data type. Short command types need a single header word. Read requests first clear the pending interrupt flags and then push their header. Long writes pack their bytes into payload words, and only after the last word do they push a header that holds the byte count. Video timing markers, end-of-transmission, null and blanking types are accepted and write nothing. Any other type is rejected. The link state gates every request. In the ultra-low-power state every request is refused. In the low-power stop state the block waits for the header FIFO to report empty, and it gives up after a bounded number of cycles. Each request ends with a one-cycle status pulse that reports accept or reject.

Top module: `dsi_cmd_writer`

## Requirements
- R1: While `link_state` is 3 (ultra-low-power), an accepted request ends in a reject status and produces no FIFO push and no interrupt clear.
- R2: While `link_state` is 1 (low-power stop), a request stalls until `hdr_empty` is high. If `hdr_empty` stays low for `TIMEOUT` cycles, the request is rejected and nothing is written.
- R3: Types 0x03, 0x13, 0x23, 0x05, 0x15 and 0x37 push one header word. Bits [7:0] hold the type (upper two bits zero), bits [15:8] hold `req_param0` and bits [23:16] hold `req_param1`. The status is accept.
- R4: Types 0x29 and 0x39 pack the stream bytes little-endian, four to a payload word, with the first byte in bits [7:0]. A final partial word holds the remaining 1 to 3 bytes in its low lanes and zeros above them.
- R5: A long write with a count below 4 pushes exactly one payload word. A count of 0 pushes one all-zero word and takes no stream bytes.
- R6: After the last payload word of a long write, one header is pushed. It holds the type in [7:0], the count's low byte in [15:8] and the count's high byte in [23:16].
- R7: Types 0x04, 0x14, 0x24 and 0x06 pulse `irq_clear` for one cycle, then push a header laid out as in R3. No payload word comes between the clear and the header.
- R8: Types 0x01, 0x11, 0x21, 0x31, 0x08, 0x09 and 0x19 are accepted without any push.
- R9: Every other type value is rejected without any push.
- R10: Nothing is pushed into a FIFO while its full flag is high. Stalled pushes complete later with unchanged data. At most one FIFO is pushed per cycle.
- R11: Each long write starts packing at byte lane 0, whatever the previous packet left behind.
- R12: Each request ends with exactly one single-cycle `done_valid` pulse, which carries `done_ok`. A new request is taken only when `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_state | input | 2 | 0 init, 1 low-power stop, 2 high-speed, 3 ultra-low-power |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle, request taken |
| req_type | input | 6 | Packet data type |
| req_count | input | 16 | Payload byte count for long writes |
| req_param0 | input | 8 | First parameter byte of short packets |
| req_param1 | input | 8 | Second parameter byte of short packets |
| byte_valid | input | 1 | Payload byte present |
| byte_ready | output | 1 | Payload byte taken |
| byte_data | input | 8 | Payload byte |
| byte_last | input | 1 | Final byte of the packet |
| hdr_empty | input | 1 | Header FIFO empty |
| hdr_full | input | 1 | Header FIFO full |
| hdr_push | output | 1 | Header FIFO write |
| hdr_data | output | 24 | Header word |
| pld_full | input | 1 | Payload FIFO full |
| pld_push | output | 1 | Payload FIFO write |
| pld_data | output | 32 | Payload word |
| irq_clear | output | 1 | Clear pending interrupt flags |
| done_valid | output | 1 | Request finished |
| done_ok | output | 1 | 1 accept, 0 reject |

## Verification
A stale byte-lane index or a packing register that was not cleared shows up in the first payload word of the next long write, because the bytes land in the wrong lanes or old bytes remain. A wrong dispatch or a lost wait state shows up within a few cycles of the request, as a missing or extra push, an `irq_clear` pulse in the wrong place, or a status pulse that arrives too early or with the wrong value. The scoreboard compares every push, clear and status event in order against values built from the requirements.

// File: rtl/dsi_cmd_writer.sv
module dsi_cmd_writer #(
  parameter int TIMEOUT = 10000,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  link_state,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [5:0]  req_type,
  input  logic [15:0] req_count,
  input  logic [7:0]  req_param0,
  input  logic [7:0]  req_param1,
  input  logic        byte_valid,
  output logic        byte_ready,
  input  logic [7:0]  byte_data,
  input  logic        byte_last,
  input  logic        hdr_empty,
  input  logic        hdr_full,
  output logic        hdr_push,
  output logic [23:0] hdr_data,
  input  logic        pld_full,
  output logic        pld_push,
  output logic [31:0] pld_data,
  output logic        irq_clear,
  output logic        done_valid,
  output logic        done_ok
);
  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_IRQ, S_PACK, S_ZERO, S_HDR, S_DONE} st_t;
  typedef enum logic [2:0] {C_BAD, C_SHORT, C_READ, C_LONG, C_NOP} cls_t;

  st_t         state;
  cls_t        cls, cls_q;
  logic [5:0]  typ_q;
  logic [15:0] cnt_q;
  logic [15:0] par_q;
  logic [CW-1:0] wait_q;
  logic [31:0] acc;
  logic [1:0]  lane;
  logic        wfull, lastw, ok_q;

  always_comb
    case (req_type)
      6'h03, 6'h13, 6'h23, 6'h05, 6'h15, 6'h37: cls = C_SHORT;
      6'h04, 6'h14, 6'h24, 6'h06:               cls = C_READ;
      6'h29, 6'h39:                             cls = C_LONG;
      6'h01, 6'h11, 6'h21, 6'h31, 6'h08,
      6'h09, 6'h19:                             cls = C_NOP;
      default:                                  cls = C_BAD;
    endcase

  function automatic st_t dispatch(input cls_t c, input logic zero);
    case (c)
      C_SHORT: return S_HDR;
      C_READ:  return S_IRQ;
      C_LONG:  return zero ? S_ZERO : S_PACK;
      default: return S_DONE;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state  <= S_IDLE;
      cls_q  <= C_BAD;
      typ_q  <= '0;
      cnt_q  <= '0;
      par_q  <= '0;
      wait_q <= '0;
      acc    <= '0;
      lane   <= '0;
      wfull  <= 1'b0;
      lastw  <= 1'b0;
      ok_q   <= 1'b0;
    end else
      case (state)
        S_IDLE:
          if (req_valid) begin
            typ_q  <= req_type;
            cnt_q  <= req_count;
            par_q  <= {req_param1, req_param0};
            cls_q  <= cls;
            wait_q <= '0;
            acc    <= '0;
            lane   <= '0;
            wfull  <= 1'b0;
            lastw  <= 1'b0;
            if (link_state == 2'd3 || cls == C_BAD) begin
              ok_q  <= 1'b0;
              state <= S_DONE;
            end else begin
              ok_q  <= 1'b1;
              state <= (link_state == 2'd1) ? S_WAIT : dispatch(cls, req_count == 16'd0);
            end
          end
        S_WAIT:
          if (hdr_empty) state <= dispatch(cls_q, cnt_q == 16'd0);
          else if (wait_q == CW'(TIMEOUT - 1)) begin
            ok_q  <= 1'b0;
            state <= S_DONE;
          end else wait_q <= wait_q + 1'b1;
        S_IRQ: state <= S_HDR;
        S_PACK:
          if (wfull) begin
            if (!pld_full) begin
              wfull <= 1'b0;
              acc   <= '0;
              if (lastw) state <= S_HDR;
            end
          end else if (byte_valid) begin
            acc[{lane, 3'b000} +: 8] <= byte_data;
            if (lane == 2'd3 || byte_last) begin
              wfull <= 1'b1;
              lane  <= '0;
              lastw <= byte_last;
            end else lane <= lane + 1'b1;
          end
        S_ZERO: if (!pld_full) state <= S_HDR;
        S_HDR:  if (!hdr_full) state <= S_DONE;
        default: state <= S_IDLE;
      endcase

  assign req_ready  = state == S_IDLE;
  assign byte_ready = state == S_PACK && !wfull;
  assign pld_push   = ((state == S_PACK && wfull) || state == S_ZERO) && !pld_full;
  assign pld_data   = acc;
  assign hdr_push   = state == S_HDR && !hdr_full;
  assign hdr_data   = (cls_q == C_LONG) ? {cnt_q[15:8], cnt_q[7:0], 2'b00, typ_q}
                                        : {par_q[15:8], par_q[7:0], 2'b00, typ_q};
  assign irq_clear  = state == S_IRQ;
  assign done_valid = state == S_DONE;
  assign done_ok    = ok_q;
endmodule

// File: rtl/dsi_cmd_writer_chk.sv
module dsi_cmd_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] link_state,
  input logic       req_valid,
  input logic       req_ready,
  input logic       hdr_full,
  input logic       hdr_push,
  input logic       pld_full,
  input logic       pld_push,
  input logic       irq_clear,
  input logic       done_valid,
  input logic       done_ok
);
  assert_ulps_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && link_state == 2'd3) |=> (done_valid && !done_ok));
  assert_no_hdr_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_push |-> !hdr_full);
  assert_no_pld_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pld_push |-> !pld_full);
  assert_one_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hdr_push, pld_push}) <= 1);
  assert_irq_then_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |=> (!pld_push && !irq_clear));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !req_ready);
endmodule

bind dsi_cmd_writer dsi_cmd_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_state(link_state), .req_valid(req_valid),
  .req_ready(req_ready), .hdr_full(hdr_full), .hdr_push(hdr_push),
  .pld_full(pld_full), .pld_push(pld_push), .irq_clear(irq_clear),
  .done_valid(done_valid), .done_ok(done_ok));

// File: tb/sim_dsi_cmd_writer.sv
module sim_dsi_cmd_writer;
  localparam int TMO = 16;
  localparam logic [3:0] K_PLD = 4'd1, K_HDR = 4'd2, K_IRQ = 4'd3, K_DONE = 4'd4;

  logic clk = 0, rst_n = 0;
  logic [1:0] link_state = 2'd2;
  logic req_valid = 0, req_ready;
  logic [5:0] req_type = 0;
  logic [15:0] req_count = 0;
  logic [7:0] req_param0 = 0, req_param1 = 0;
  logic byte_valid = 0, byte_ready, byte_last = 0;
  logic [7:0] byte_data = 0;
  logic hdr_empty = 1, hdr_full = 0, hdr_push, pld_full = 0, pld_push;
  logic [23:0] hdr_data;
  logic [31:0] pld_data;
  logic irq_clear, done_valid, done_ok;

  int checks = 0, fails = 0;
  logic [35:0] exp_q[$];
  string tag_q[$];
  logic [7:0] buf_q[$];

  always #2.5 clk = ~clk;

  dsi_cmd_writer #(.TIMEOUT(TMO)) u0 (.*);

  task automatic expect_ev(input logic [3:0] k, input logic [31:0] d, input string tag);
    exp_q.push_back({k, d});
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [3:0] k, input logic [31:0] d);
    logic [35:0] e;
    string t;
    checks++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R8/R9 unexpected event: actual kind %0d data %h, expected none", k, d);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e != {k, d}) begin
        fails++;
        $display("FAIL %s: actual kind %0d data %h, expected kind %0d data %h", t, k, d, e[35:32], e[31:0]);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (pld_push)  observe(K_PLD, pld_data);
    if (hdr_push)  observe(K_HDR, {8'h00, hdr_data});
    if (irq_clear) observe(K_IRQ, 32'd0);
    if (done_valid) observe(K_DONE, {31'd0, done_ok});
    if (pld_full || hdr_full) begin
      checks++;
      if ((pld_full && pld_push) || (hdr_full && hdr_push)) begin
        fails++;
        $display("FAIL R10: push while full, actual pld %b hdr %b, expected 0 0", pld_push, hdr_push);
      end
    end
  end

  task automatic chk(input logic c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [5:0] t, input logic [15:0] n, input logic [7:0] a, b, input bit bytes);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1; req_type = t; req_count = n; req_param0 = a; req_param1 = b;
    @(posedge clk); #1;
    req_valid = 0;
    if (bytes)
      for (int i = 0; i < int'(n); i++) begin
        bit got;
        byte_valid = 1; byte_data = buf_q[i]; byte_last = (i == int'(n) - 1);
        got = 0;
        while (!got) begin
          @(negedge clk); got = byte_ready;
          @(posedge clk); #1;
        end
      end
    byte_valid = 0; byte_last = 0;
    @(negedge clk);
    while (!done_valid) @(negedge clk);
  endtask

  task automatic long_wr(input logic [5:0] t, input int n, input string tag);
    if (n == 0) expect_ev(K_PLD, 32'd0, {tag, " R5"});
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] word = 0;
      for (int k = 0; k < 4; k++)
        if (4 * w + k < n) word[8*k +: 8] = buf_q[4*w+k];
      expect_ev(K_PLD, word, {tag, " R4"});
    end
    expect_ev(K_HDR, {8'h00, n[15:8], n[7:0], 2'b00, t}, "R6");
    expect_ev(K_DONE, 32'd1, "R12");
    send(t, n[15:0], 8'h00, 8'h00, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1 && !done_valid && !hdr_push && !pld_push && !irq_clear,
        "R12 reset state", {req_ready, done_valid, hdr_push, pld_push}, 32'h8);

    expect_ev(K_HDR, 32'h00483615, "R3"); expect_ev(K_DONE, 1, "R3");
    send(6'h15, 0, 8'h36, 8'h48, 0);
    expect_ev(K_HDR, 32'h00000003, "R3"); expect_ev(K_DONE, 1, "R3");
    send(6'h03, 0, 8'h00, 8'h00, 0);

    link_state = 2'd3;
    expect_ev(K_DONE, 0, "R1"); send(6'h15, 0, 8'h11, 8'h22, 0);
    expect_ev(K_DONE, 0, "R1"); send(6'h39, 0, 8'h00, 8'h00, 0);
    link_state = 2'd2;

    expect_ev(K_DONE, 0, "R9"); send(6'h3E, 0, 8'h01, 8'h02, 0);
    expect_ev(K_DONE, 0, "R9"); send(6'h02, 0, 8'h01, 8'h02, 0);
    expect_ev(K_DONE, 1, "R8"); send(6'h09, 0, 8'h01, 8'h02, 0);
    expect_ev(K_DONE, 1, "R8"); send(6'h21, 0, 8'h01, 8'h02, 0);

    expect_ev(K_IRQ, 0, "R7"); expect_ev(K_HDR, 32'h00BCDA06, "R7"); expect_ev(K_DONE, 1, "R7");
    send(6'h06, 0, 8'hDA, 8'hBC, 0);

    buf_q = {8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16};
    long_wr(6'h39, 6, "R4");
    buf_q = {8'hAA, 8'hBB};
    long_wr(6'h29, 2, "R11 R5");
    buf_q = {8'hC1, 8'hC2, 8'hC3};
    long_wr(6'h39, 3, "R5");
    buf_q = {};
    long_wr(6'h29, 0, "R5");
    buf_q = {};
    for (int i = 0; i < 300; i++) buf_q.push_back(8'(i * 7 + 3));
    long_wr(6'h39, 300, "R6");

    buf_q = {};
    for (int i = 0; i < 13; i++) buf_q.push_back(8'(8'hF0 + i));
    fork
      long_wr(6'h29, 13, "R10");
      begin
        repeat (5) @(posedge clk); #1 pld_full = 1;
        repeat (6) @(posedge clk); #1 pld_full = 0;
      end
    join
    expect_ev(K_HDR, 32'h00020115, "R10"); expect_ev(K_DONE, 1, "R10");
    fork
      send(6'h15, 0, 8'h01, 8'h02, 0);
      begin hdr_full = 1; repeat (4) @(posedge clk); #1 hdr_full = 0; end
    join

    link_state = 2'd1;
    expect_ev(K_HDR, 32'h00443305, "R2"); expect_ev(K_DONE, 1, "R2");
    send(6'h05, 0, 8'h33, 8'h44, 0);
    hdr_empty = 0;
    expect_ev(K_DONE, 0, "R2 timeout");
    send(6'h05, 0, 8'h55, 8'h66, 0);
    expect_ev(K_HDR, 32'h00887737, "R2"); expect_ev(K_DONE, 1, "R2");
    fork
      send(6'h37, 0, 8'h77, 8'h88, 0);
      begin repeat (6) @(posedge clk); #1 hdr_empty = 1; end
    join
    link_state = 2'd2;

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R12 pending events", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R12 watchdog: actual hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule